// File: doc/BRIEF.md
# Two-Cycle Fill Arbiter for Split Caches

This block sits between an instruction cache, a data cache and a single-port main memory, and decides which cache gets the next line fill. It serves one fill at a time. A fill opens with an issue cycle, in which the memory read is launched. It closes with one busy cycle, in which the returned word is handed to the cache that asked for it, together with a done pulse meant only for that cache.

When both caches ask at once, the data cache always wins. The losing request is held by its cache and is served on the first idle cycle in which the data cache is not asking. Write-backs from the data cache are not fills. They go straight through to the memory write port in the same cycle and never hold up the arbiter.

A write-back that lands on the address being filled, in the issue cycle of that fill, is caught by the arbiter. The fill then returns the written word rather than the stale word read from memory.

Top module: `fill_arbiter`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) leaves fill_busy low after that edge. While rst is high, no read is issued (mem_rd_en low), so a request present during reset is only granted after rst falls.
- R2: In an idle cycle (fill_busy low) with a request present, mem_rd_en is high in that same cycle and mem_rd_addr carries the winner's address. In the next cycle fill_busy is high and fill_addr equals that address.
- R3: In the busy cycle, exactly the owning cache's done output is high. fill_data carries the memory word read at the issue cycle. Outside a busy cycle, both done outputs are low and fill_data is zero.
- R4: When dc_req and ic_req are both high in an idle cycle, the data-cache address is issued. This holds on every such cycle, even if the instruction cache has waited.
- R5: No read is issued while fill_busy is high. A request that lost arbitration is issued in the first following idle cycle in which it is the highest-priority request.
- R6: fill_busy stays high for exactly one cycle per fill, so a new fill can be issued no sooner than the cycle after the busy cycle.
- R7: mem_wr_en, mem_wr_addr and mem_wr_data follow wb_en, wb_addr and wb_data in the same cycle, whether the arbiter is idle or busy, and a write-back never changes fill_busy.
- R8: A write-back in the issue cycle whose address equals the issued address makes that fill return wb_data in its busy cycle. A write-back to any other address leaves the fill returning the memory word.
- R9: With no request present and fill_busy low, mem_rd_en stays low and no done output is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ic_req | input | 1 | Instruction-cache fill request, held until ic_done |
| ic_addr | input | AW | Instruction-cache fill address |
| dc_req | input | 1 | Data-cache fill request, held until dc_done |
| dc_addr | input | AW | Data-cache fill address |
| wb_en | input | 1 | Data-cache write-back strobe |
| wb_addr | input | AW | Write-back address |
| wb_data | input | DW | Write-back data |
| mem_rd_en | output | 1 | Memory read launch (issue cycle) |
| mem_rd_addr | output | AW | Memory read address |
| mem_rd_data | input | DW | Memory read data, valid one cycle after launch |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | AW | Memory write address |
| mem_wr_data | output | DW | Memory write data |
| ic_done | output | 1 | Fill delivered to the instruction cache |
| dc_done | output | 1 | Fill delivered to the data cache |
| fill_data | output | DW | Fill word, valid while a done output is high |
| fill_busy | output | 1 | A fill is in its busy cycle |
| fill_addr | output | AW | Address of the fill in progress |

## Verification
The bench presents simultaneous requests with the data cache held high across several fills. An arbiter with reversed or rotating priority would show ic_done where dc_done is expected.

It drops a write-back onto the issued address in the issue cycle. A design without the capture register would return the stale memory word. It also places write-backs to neighbouring addresses and inside busy cycles, where a loose compare would wrongly substitute data, or where write-back gating would hold up the next fill.

Reset is asserted while a request is held and again in a busy cycle. A design that let a grant escape during reset, or kept fill_busy set across it, would issue a read too early or never return to idle.

// File: rtl/fill_arb_pkg.sv
package fill_arb_pkg;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_IC   = 2'd1,
    OWN_DC   = 2'd2
  } fill_owner_e;

  // Fixed priority: data cache ahead of instruction cache.
  function automatic fill_owner_e pick_owner(input logic dc_req, input logic ic_req);
    if (dc_req)      return OWN_DC;
    else if (ic_req) return OWN_IC;
    else             return OWN_NONE;
  endfunction

  // Requester index used for done fan-out: 0 = instruction, 1 = data.
  function automatic fill_owner_e owner_of_index(input int idx);
    return (idx == 0) ? OWN_IC : OWN_DC;
  endfunction

endpackage

// File: rtl/fill_arb_select.sv
module fill_arb_select
  import fill_arb_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          rst,
  input  logic          busy,
  input  logic          ic_req,
  input  logic [AW-1:0] ic_addr,
  input  logic          dc_req,
  input  logic [AW-1:0] dc_addr,
  output logic          grant,
  output fill_owner_e   grant_owner,
  output logic [AW-1:0] grant_addr
);

  // Grants only open while idle and out of reset.
  always_comb begin
    if (rst || busy) grant_owner = OWN_NONE;
    else             grant_owner = pick_owner(dc_req, ic_req);
  end

  assign grant      = (grant_owner != OWN_NONE);
  assign grant_addr = (grant_owner == OWN_DC) ? dc_addr : ic_addr;

endmodule

// File: rtl/fill_arb_track.sv
module fill_arb_track
  import fill_arb_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          grant,
  input  fill_owner_e   grant_owner,
  input  logic [AW-1:0] grant_addr,
  output logic          busy,
  output fill_owner_e   owner,
  output logic [AW-1:0] fill_addr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      owner     <= OWN_NONE;
      fill_addr <= '0;
    end else if (grant) begin
      busy      <= 1'b1;
      owner     <= grant_owner;
      fill_addr <= grant_addr;
    end else if (busy) begin
      busy  <= 1'b0;
      owner <= OWN_NONE;
    end
  end

endmodule

// File: rtl/fill_arb_bypass.sv
module fill_arb_bypass #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          grant,
  input  logic [AW-1:0] grant_addr,
  input  logic          wb_en,
  input  logic [AW-1:0] wb_addr,
  input  logic [DW-1:0] wb_data,
  input  logic          busy,
  input  logic [DW-1:0] mem_rd_data,
  output logic          byp_hit,
  output logic [DW-1:0] fill_data
);

  logic          byp_valid;
  logic [DW-1:0] byp_data;

  // Write-back colliding with the read launched this cycle.
  assign byp_hit = grant && wb_en && (wb_addr == grant_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      byp_valid <= 1'b0;
      byp_data  <= '0;
    end else if (grant) begin
      byp_valid <= byp_hit;
      byp_data  <= wb_data;
    end
  end

  always_comb begin
    if (!busy)          fill_data = '0;
    else if (byp_valid) fill_data = byp_data;
    else                fill_data = mem_rd_data;
  end

endmodule

// File: rtl/fill_arbiter.sv
module fill_arbiter
  import fill_arb_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ic_req,
  input  logic [AW-1:0] ic_addr,
  input  logic          dc_req,
  input  logic [AW-1:0] dc_addr,
  input  logic          wb_en,
  input  logic [AW-1:0] wb_addr,
  input  logic [DW-1:0] wb_data,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [DW-1:0] mem_rd_data,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  output logic          ic_done,
  output logic          dc_done,
  output logic [DW-1:0] fill_data,
  output logic          fill_busy,
  output logic [AW-1:0] fill_addr
);

  localparam int NREQ = 2;

  logic          grant;
  fill_owner_e   grant_owner;
  logic [AW-1:0] grant_addr;
  logic          busy;
  fill_owner_e   owner;
  logic          byp_hit;
  logic [NREQ-1:0] done_vec;

  fill_arb_select #(.AW(AW)) u_select (
    .rst         (rst),
    .busy        (busy),
    .ic_req      (ic_req),
    .ic_addr     (ic_addr),
    .dc_req      (dc_req),
    .dc_addr     (dc_addr),
    .grant       (grant),
    .grant_owner (grant_owner),
    .grant_addr  (grant_addr)
  );

  fill_arb_track #(.AW(AW)) u_track (
    .clk         (clk),
    .rst         (rst),
    .grant       (grant),
    .grant_owner (grant_owner),
    .grant_addr  (grant_addr),
    .busy        (busy),
    .owner       (owner),
    .fill_addr   (fill_addr)
  );

  fill_arb_bypass #(.AW(AW), .DW(DW)) u_bypass (
    .clk         (clk),
    .rst         (rst),
    .grant       (grant),
    .grant_addr  (grant_addr),
    .wb_en       (wb_en),
    .wb_addr     (wb_addr),
    .wb_data     (wb_data),
    .busy        (busy),
    .mem_rd_data (mem_rd_data),
    .byp_hit     (byp_hit),
    .fill_data   (fill_data)
  );

  // One done line per requester, raised only for the owner in the busy cycle.
  for (genvar g = 0; g < NREQ; g++) begin : g_done
    assign done_vec[g] = busy && (owner == owner_of_index(g));
  end

  assign ic_done     = done_vec[0];
  assign dc_done     = done_vec[1];
  assign fill_busy   = busy;
  assign mem_rd_en   = grant;
  assign mem_rd_addr = grant_addr;

  // Write-backs bypass arbitration entirely.
  assign mem_wr_en   = wb_en;
  assign mem_wr_addr = wb_addr;
  assign mem_wr_data = wb_data;

endmodule

// File: rtl/fill_arbiter_chk.sv
module fill_arbiter_chk #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          ic_req,
  input logic          dc_req,
  input logic [AW-1:0] dc_addr,
  input logic          wb_en,
  input logic [AW-1:0] wb_addr,
  input logic [DW-1:0] wb_data,
  input logic          mem_rd_en,
  input logic [AW-1:0] mem_rd_addr,
  input logic          mem_wr_en,
  input logic [AW-1:0] mem_wr_addr,
  input logic [DW-1:0] mem_wr_data,
  input logic          ic_done,
  input logic          dc_done,
  input logic [DW-1:0] fill_data,
  input logic          fill_busy,
  input logic [AW-1:0] fill_addr
);

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> !fill_busy);

  // R2
  issue_to_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> fill_busy && (fill_addr == $past(mem_rd_addr)));

  // R3
  single_done_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ic_done, dc_done}) && (fill_busy == (ic_done || dc_done)));

  // R4
  dc_first_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && dc_req) |-> (mem_rd_addr == dc_addr));

  // R5
  no_issue_busy_chk: assert property (@(posedge clk) disable iff (rst)
    fill_busy |-> !mem_rd_en);

  // R6
  one_busy_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    fill_busy |=> !fill_busy);

  // R7
  wb_through_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_en == wb_en) && (!wb_en || (mem_wr_addr == wb_addr && mem_wr_data == wb_data)));

  // R8
  wb_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && wb_en && (wb_addr == mem_rd_addr)) |=> (fill_data == $past(wb_data)));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!ic_req && !dc_req) |-> !mem_rd_en);

endmodule

bind fill_arbiter fill_arbiter_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ic_req      (ic_req),
  .dc_req      (dc_req),
  .dc_addr     (dc_addr),
  .wb_en       (wb_en),
  .wb_addr     (wb_addr),
  .wb_data     (wb_data),
  .mem_rd_en   (mem_rd_en),
  .mem_rd_addr (mem_rd_addr),
  .mem_wr_en   (mem_wr_en),
  .mem_wr_addr (mem_wr_addr),
  .mem_wr_data (mem_wr_data),
  .ic_done     (ic_done),
  .dc_done     (dc_done),
  .fill_data   (fill_data),
  .fill_busy   (fill_busy),
  .fill_addr   (fill_addr)
);

// File: tb/fill_arbiter_bench.sv
`timescale 1ns/1ps
module fill_arbiter_bench;

  localparam int AW = 8;
  localparam int DW = 16;

  function automatic logic [15:0] pat(input logic [7:0] a);
    return {a, ~a};
  endfunction

  typedef struct packed {
    logic        rst;
    logic        icr;
    logic [7:0]  ica;
    logic        dcr;
    logic [7:0]  dca;
    logic        wbe;
    logic [7:0]  wba;
    logic [15:0] wbd;
    logic        erd;
    logic [7:0]  era;
    logic        ebusy;
    logic        eicd;
    logic        edcd;
    logic [15:0] edata;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,8'h00,1'b0,8'h00,1'b0,8'h00,16'h0000, 1'b0,8'h00,1'b0,1'b0,1'b0,16'h0000,4'd1}, // R1
    '{1'b0,1'b0,8'h00,1'b0,8'h00,1'b0,8'h00,16'h0000, 1'b0,8'h00,1'b0,1'b0,1'b0,16'h0000,4'd9}, // R9
    '{1'b0,1'b1,8'h0A,1'b0,8'h00,1'b0,8'h00,16'h0000, 1'b1,8'h0A,1'b0,1'b0,1'b0,16'h0000,4'd2}, // R2
    '{1'b0,1'b1,8'h0A,1'b0,8'h00,1'b0,8'h00,16'h0000, 1'b0,8'h00,1'b1,1'b1,1'b0,pat(8'h0A),4'd3}, // R3
    '{1'b0,1'b1,8'h1E,1'b1,8'h14,1'b0,8'h00,16'h0000, 1'b1,8'h14,1'b0,1'b0,1'b0,16'h0000,4'd4}, // R4
    '{1'b0,1'b1,8'h1E,1'b1,8'h14,1'b0,8'h00,16'h0000, 1'b0,8'h00,1'b1,1'b0,1'b1,pat(8'h14),4'd5}, // R5
    '{1'b0,1'b1,8'h1E,1'b0,8'h00,1'b0,8'h00,16'h0000, 1'b1,8'h1E,1'b0,1'b0,1'b0,16'h0000,4'd5}, // R5
    '{1'b0,1'b1,8'h1E,1'b0,8'h00,1'b0,8'h00,16'h0000, 1'b0,8'h00,1'b1,1'b1,1'b0,pat(8'h1E),4'd3}, // R3
    '{1'b0,1'b0,8'h00,1'b1,8'h28,1'b1,8'h28,16'hBEEF, 1'b1,8'h28,1'b0,1'b0,1'b0,16'h0000,4'd8}, // R8
    '{1'b0,1'b0,8'h00,1'b1,8'h28,1'b0,8'h00,16'h0000, 1'b0,8'h00,1'b1,1'b0,1'b1,16'hBEEF,4'd8}, // R8
    '{1'b0,1'b0,8'h00,1'b1,8'h32,1'b1,8'h33,16'h1234, 1'b1,8'h32,1'b0,1'b0,1'b0,16'h0000,4'd8}, // R8
    '{1'b0,1'b0,8'h00,1'b1,8'h32,1'b0,8'h00,16'h0000, 1'b0,8'h00,1'b1,1'b0,1'b1,pat(8'h32),4'd8}, // R8
    '{1'b0,1'b0,8'h00,1'b1,8'h33,1'b0,8'h00,16'h0000, 1'b1,8'h33,1'b0,1'b0,1'b0,16'h0000,4'd7}, // R7
    '{1'b0,1'b0,8'h00,1'b1,8'h33,1'b0,8'h00,16'h0000, 1'b0,8'h00,1'b1,1'b0,1'b1,16'h1234,4'd7}, // R7
    '{1'b0,1'b0,8'h00,1'b1,8'h3C,1'b0,8'h00,16'h0000, 1'b1,8'h3C,1'b0,1'b0,1'b0,16'h0000,4'd2}, // R2
    '{1'b0,1'b0,8'h00,1'b1,8'h3C,1'b1,8'h3D,16'h7777, 1'b0,8'h00,1'b1,1'b0,1'b1,pat(8'h3C),4'd7}, // R7
    '{1'b0,1'b0,8'h00,1'b1,8'h3D,1'b0,8'h00,16'h0000, 1'b1,8'h3D,1'b0,1'b0,1'b0,16'h0000,4'd6}, // R6
    '{1'b0,1'b0,8'h00,1'b1,8'h3D,1'b0,8'h00,16'h0000, 1'b0,8'h00,1'b1,1'b0,1'b1,16'h7777,4'd7}, // R7
    '{1'b1,1'b1,8'h46,1'b0,8'h00,1'b0,8'h00,16'h0000, 1'b0,8'h00,1'b0,1'b0,1'b0,16'h0000,4'd1}, // R1
    '{1'b0,1'b1,8'h46,1'b0,8'h00,1'b0,8'h00,16'h0000, 1'b1,8'h46,1'b0,1'b0,1'b0,16'h0000,4'd1}, // R1
    '{1'b0,1'b1,8'h46,1'b0,8'h00,1'b0,8'h00,16'h0000, 1'b0,8'h00,1'b1,1'b1,1'b0,pat(8'h46),4'd3}, // R3
    '{1'b0,1'b0,8'h00,1'b0,8'h00,1'b0,8'h00,16'h0000, 1'b0,8'h00,1'b0,1'b0,1'b0,16'h0000,4'd6}  // R6
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ic_req = 1'b0, dc_req = 1'b0, wb_en = 1'b0;
  logic [AW-1:0] ic_addr = '0, dc_addr = '0, wb_addr = '0;
  logic [DW-1:0] wb_data = '0;
  logic          mem_rd_en, mem_wr_en, ic_done, dc_done, fill_busy;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr, fill_addr;
  logic [DW-1:0] mem_rd_data, mem_wr_data, fill_data;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  fill_arbiter #(.AW(AW), .DW(DW)) u_fill_arbiter (
    .clk(clk), .rst(rst),
    .ic_req(ic_req), .ic_addr(ic_addr),
    .dc_req(dc_req), .dc_addr(dc_addr),
    .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .ic_done(ic_done), .dc_done(dc_done), .fill_data(fill_data),
    .fill_busy(fill_busy), .fill_addr(fill_addr)
  );

  // Main memory model: registered read, read-before-write at the same edge.
  logic [DW-1:0] mem_arr [256];
  logic [DW-1:0] rd_q = '0;
  assign mem_rd_data = rd_q;
  initial for (int i = 0; i < 256; i++) mem_arr[i] = pat(i[7:0]);
  always @(posedge clk) begin
    if (mem_rd_en) rd_q <= mem_arr[mem_rd_addr];
    if (mem_wr_en) mem_arr[mem_wr_addr] <= mem_wr_data;
  end

  task automatic drive(input logic r, input logic icr, input logic [7:0] ica,
                       input logic dcr, input logic [7:0] dca,
                       input logic wbe, input logic [7:0] wba, input logic [15:0] wbd);
    @(negedge clk);
    rst = r; ic_req = icr; ic_addr = ica; dc_req = dcr; dc_addr = dca;
    wb_en = wbe; wb_addr = wba; wb_data = wbd;
    #1;
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    // Vector table walk
    for (int k = 0; k < NV; k++) begin
      vec_t v = VECS[k];
      drive(v.rst, v.icr, v.ica, v.dcr, v.dca, v.wbe, v.wba, v.wbd);
      vectors++;
      if (mem_rd_en !== v.erd || (v.erd && mem_rd_addr !== v.era) ||
          fill_busy !== v.ebusy || ic_done !== v.eicd || dc_done !== v.edcd ||
          fill_data !== v.edata) begin
        miscompares++;
        $display("FAIL R%0d vec %0d: actual rd=%b a=%h busy=%b icd=%b dcd=%b d=%h expected rd=%b a=%h busy=%b icd=%b dcd=%b d=%h",
                 v.req, k, mem_rd_en, mem_rd_addr, fill_busy, ic_done, dc_done, fill_data,
                 v.erd, v.era, v.ebusy, v.eicd, v.edcd, v.edata);
      end
    end

    // R7: write-back passes straight through while idle, busy untouched
    drive(1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'h05, 16'hABCD);
    check("R7 wr port", {mem_wr_en, mem_wr_addr, mem_wr_data, fill_busy},
          {1'b1, 8'h05, 16'hABCD, 1'b0});

    // R4: data cache held across back-to-back fills starves the instruction cache
    drive(1'b0, 1'b1, 8'h90, 1'b1, 8'h80, 1'b0, 8'h00, 16'h0);
    check("R4 issue dc", {mem_rd_en, mem_rd_addr}, {1'b1, 8'h80});
    drive(1'b0, 1'b1, 8'h90, 1'b1, 8'h80, 1'b0, 8'h00, 16'h0);
    check("R2 fill_addr", {fill_busy, fill_addr, dc_done, ic_done}, {1'b1, 8'h80, 1'b1, 1'b0});
    drive(1'b0, 1'b1, 8'h90, 1'b1, 8'h81, 1'b0, 8'h00, 16'h0);
    check("R4 reissue dc", {mem_rd_en, mem_rd_addr}, {1'b1, 8'h81});
    drive(1'b0, 1'b1, 8'h90, 1'b1, 8'h81, 1'b0, 8'h00, 16'h0);
    check("R4 dc done", {dc_done, ic_done, fill_data}, {1'b1, 1'b0, pat(8'h81)});

    // R1: reset in the busy cycle ends the fill, then the held request regrants
    drive(1'b0, 1'b1, 8'h90, 1'b0, 8'h00, 1'b0, 8'h00, 16'h0);
    check("R5 ic granted", {mem_rd_en, mem_rd_addr}, {1'b1, 8'h90});
    drive(1'b1, 1'b1, 8'h90, 1'b0, 8'h00, 1'b0, 8'h00, 16'h0);
    check("R1 no issue in reset", {mem_rd_en}, {1'b0});
    drive(1'b0, 1'b1, 8'h90, 1'b0, 8'h00, 1'b0, 8'h00, 16'h0);
    check("R1 idle after reset", {fill_busy, ic_done, mem_rd_en}, {1'b0, 1'b0, 1'b1});
    drive(1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 16'h0);
    check("R3 ic done after regrant", {ic_done, fill_data}, {1'b1, pat(8'h90)});

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule